// File: doc/BRIEF.md
# Eight-Point Radix-2 FFT Engine

This block turns eight complex fixed-point samples into their eight-point discrete Fourier transform. Software or an upstream block writes the samples one at a time in natural index order. The block files each sample at the bit-reversed position of its index in a small in-place working memory. A start pulse then runs three decimation-in-time stages of four butterflies each. A single shared butterfly performs all twelve of them, one per clock cycle. When the last stage has been written back, `done` rises, and the spectrum can be read in natural bin order through an asynchronous read port.

Every butterfly output is halved, so the transform returns X(k)/8. This keeps full-scale inputs from overflowing the 16-bit datapath. Each stage applies the twiddle W8^k = e^(-j2πk/8) from a constant lookup, except the first stage, where k is always zero and no multiply is done.

Top module: `fft8_engine`

## Requirements
- R1: After synchronous reset, `busy` and `done` are both 0 and all eight result words read as zero.
- R2: A write with `wr_en` high while `busy` is low stores (`wr_re`, `wr_im`) as sample x(`wr_addr`). Bin k of the result is later read at `rd_addr` = k.
- R3: A `start` sampled high while idle sets `busy` at that clock edge. `busy` falls and `done` rises exactly 12 clock edges later.
- R4: A single nonzero sample x(0) = (8000, 0) yields all eight bins equal to (1000, 0).
- R5: A constant input of (800, 0) on every sample yields bin 0 = (800, 0) and every other bin = (0, 0).
- R6: A butterfly with twiddle index k > 0 forms t = W·b. Each part of t is the exact real sum of products plus 2^14, arithmetically shifted right by 15. The twiddle constants (re, im) are W^1 = (23170, −23170), W^2 = (0, −32768) and W^3 = (−23170, −23170). With k = 0, t = b. Stage s (0..2) pairs the slots at distance 2^s and uses k = (butterfly position within its group) · 2^(2−s).
- R7: The butterfly outputs are floor((a + t)/2) and floor((a − t)/2), computed per part and saturated to [−32768, 32767]. For example, x(0) = (3, −3) with all other samples zero gives every bin = (0, −1).
- R8: While `busy` is high, `wr_en` and `start` are ignored. The run still ends after 12 edges, and its result matches the data that was loaded before start.
- R9: `done` stays high, and the results stay readable, until the next accepted `start`, which clears `done` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | 3 | Natural-order sample index |
| wr_re | input | 16 | Sample real part, signed |
| wr_im | input | 16 | Sample imaginary part, signed |
| start | input | 1 | Begin a transform |
| rd_addr | input | 3 | Result bin index |
| rd_re | output | 16 | Real part of the selected bin |
| rd_im | output | 16 | Imaginary part of the selected bin |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Results valid |

## Verification
The hardest case to reach is a write and a restart that arrive in the middle of a run. That stimulus must not corrupt the in-place memory or stretch the twelve-cycle schedule. The bench raises `wr_en` with a junk sample and `start` together on the third compute cycle. It then checks both the completion cycle and every bin against the result predicted from the data loaded before the run. Saturation and the floor rounding are driven with near full-scale and odd-valued inputs, so that the clamp and the shift sign both show up in the bins.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
    localparam int DW    = 16;
    localparam int LOGN  = 3;
    localparam int NPT   = 1 << LOGN;
    localparam int NBF   = NPT / 2;
    localparam int NCYC  = NBF * LOGN;
    localparam int CW    = $clog2(NCYC);
    localparam int KW    = LOGN - 1;
    localparam int PW    = 2 * DW + 1;
    localparam int TWW   = DW + 2;
    localparam int SUMW  = DW + 3;

    typedef logic [LOGN-1:0]         idx_t;
    typedef logic [KW-1:0]           twk_t;
    typedef logic signed [PW-1:0]    prod_t;
    typedef logic signed [TWW-1:0]   tprod_t;
    typedef logic signed [SUMW-1:0]  wide_t;
    typedef logic signed [DW-1:0]    word_t;

    typedef struct packed {
        word_t re;
        word_t im;
    } cplx_t;

    localparam wide_t WMAX = wide_t'((1 << (DW - 1)) - 1);
    localparam wide_t WMIN = -wide_t'(1 << (DW - 1));
    localparam prod_t RND  = prod_t'(1 << (DW - 2));

    function automatic idx_t bit_reverse(idx_t i);
        idx_t r;
        for (int b = 0; b < LOGN; b++) r[b] = i[LOGN-1-b];
        return r;
    endfunction

    function automatic cplx_t twiddle(twk_t k);
        cplx_t w;
        case (k)
            2'd1:    begin w.re = 16'sd23170;  w.im = -16'sd23170; end
            2'd2:    begin w.re = 16'sd0;      w.im = -16'sd32768; end
            2'd3:    begin w.re = -16'sd23170; w.im = -16'sd23170; end
            default: begin w.re = 16'sd32767;  w.im = 16'sd0;      end
        endcase
        return w;
    endfunction

    function automatic word_t clamp(wide_t v);
        if (v > WMAX) return word_t'(WMAX);
        if (v < WMIN) return word_t'(WMIN);
        return word_t'(v);
    endfunction
endpackage

// File: rtl/fft8_seq.sv
module fft8_seq
    import fft8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output idx_t top_idx,
    output idx_t bot_idx,
    output twk_t tw_k
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(NCYC - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Stage s pairs slots 2^s apart; position p within the group picks W^(p*2^(2-s)).
    always_comb begin
        int s, b, h, p, g, t;
        s = int'(cnt) / NBF;
        b = int'(cnt) % NBF;
        h = 1 << s;
        p = b & (h - 1);
        g = b >> s;
        t = g * 2 * h + p;
        top_idx = idx_t'(t);
        bot_idx = idx_t'(t + h);
        tw_k    = twk_t'(p << (KW - s));
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(NCYC - 1));
    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));
    // R3
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && $past(cnt) == CW'(NCYC - 1)));
    // R9
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != CW'(NCYC - 1)) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly
    import fft8_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  twk_t  k,
    output cplx_t y_sum,
    output cplx_t y_dif
);
    cplx_t  w;
    prod_t  pr, pi;
    tprod_t tr, ti;
    wide_t  sr, si, dr, di;

    always_comb begin
        w  = twiddle(k);
        pr = prod_t'(w.re) * prod_t'(b.re) - prod_t'(w.im) * prod_t'(b.im);
        pi = prod_t'(w.re) * prod_t'(b.im) + prod_t'(w.im) * prod_t'(b.re);
        if (k == '0) begin
            tr = tprod_t'(b.re);
            ti = tprod_t'(b.im);
        end else begin
            tr = tprod_t'((pr + RND) >>> (DW - 1));
            ti = tprod_t'((pi + RND) >>> (DW - 1));
        end
        sr = wide_t'(a.re) + wide_t'(tr);
        si = wide_t'(a.im) + wide_t'(ti);
        dr = wide_t'(a.re) - wide_t'(tr);
        di = wide_t'(a.im) - wide_t'(ti);
        y_sum.re = clamp(sr >>> 1);
        y_sum.im = clamp(si >>> 1);
        y_dif.re = clamp(dr >>> 1);
        y_dif.im = clamp(di >>> 1);
    end
endmodule

// File: rtl/fft8_regs.sv
module fft8_regs
    import fft8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bf_we,
    input  idx_t  a_addr,
    input  idx_t  b_addr,
    input  cplx_t a_wdata,
    input  cplx_t b_wdata,
    output cplx_t a_rdata,
    output cplx_t b_rdata,
    input  logic  ext_we,
    input  idx_t  ext_addr,
    input  cplx_t ext_wdata,
    input  idx_t  rd_addr,
    output cplx_t rd_data
);
    cplx_t mem [NPT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPT; i++) mem[i] <= '0;
        end else if (bf_we) begin
            mem[a_addr] <= a_wdata;
            mem[b_addr] <= b_wdata;
        end else if (ext_we) begin
            mem[ext_addr] <= ext_wdata;
        end
    end

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fft8_engine.sv
module fft8_engine
    import fft8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic signed [15:0] wr_re,
    input  logic signed [15:0] wr_im,
    input  logic              start,
    input  logic [2:0]        rd_addr,
    output logic signed [15:0] rd_re,
    output logic signed [15:0] rd_im,
    output logic              busy,
    output logic              done
);
    idx_t  top_idx, bot_idx;
    twk_t  tw_k;
    cplx_t a_rd, b_rd, y_sum, y_dif, rd_word, in_word;

    assign in_word.re = wr_re;
    assign in_word.im = wr_im;

    fft8_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .top_idx (top_idx),
        .bot_idx (bot_idx),
        .tw_k    (tw_k)
    );

    fft8_bfly u_bfly (
        .a     (a_rd),
        .b     (b_rd),
        .k     (tw_k),
        .y_sum (y_sum),
        .y_dif (y_dif)
    );

    fft8_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bf_we     (busy),
        .a_addr    (top_idx),
        .b_addr    (bot_idx),
        .a_wdata   (y_sum),
        .b_wdata   (y_dif),
        .a_rdata   (a_rd),
        .b_rdata   (b_rd),
        .ext_we    (wr_en && !busy),
        .ext_addr  (bit_reverse(idx_t'(wr_addr))),
        .ext_wdata (in_word),
        .rd_addr   (idx_t'(rd_addr)),
        .rd_data   (rd_word)
    );

    assign rd_re = rd_word.re;
    assign rd_im = rd_word.im;
endmodule

// File: tb/sim_fft8_engine.sv
module sim_fft8_engine;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic signed [15:0] wr_re = '0, wr_im = '0;
    logic start = 1'b0;
    logic [2:0] rd_addr = '0;
    logic signed [15:0] rd_re, rd_im;
    logic busy, done;

    int checks = 0;
    int failures = 0;
    int exp_re_q[$];
    int exp_im_q[$];
    int xr[8], xi[8];

    always #2 clk = ~clk;

    fft8_engine u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_re(wr_re), .wr_im(wr_im), .start(start), .rd_addr(rd_addr),
        .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .done(done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Reference model from R6/R7: in-place DIT on bit-reversed input.
    task automatic push_model();
        longint mr[8], mi[8];
        int wre[4] = '{32767, 23170, 0, -23170};
        int wim[4] = '{0, -23170, -32768, -23170};
        for (int n = 0; n < 8; n++) begin
            int r = ((n & 1) << 2) | (n & 2) | ((n >> 2) & 1);
            mr[r] = xr[n]; mi[r] = xi[n];
        end
        for (int s = 0; s < 3; s++) begin
            int h = 1 << s;
            for (int g = 0; g < 8; g += 2 * h) begin
                for (int p = 0; p < h; p++) begin
                    int k = p << (2 - s);
                    longint tr, ti, ar, ai;
                    ar = mr[g + p]; ai = mi[g + p];
                    if (k == 0) begin
                        tr = mr[g + p + h]; ti = mi[g + p + h];
                    end else begin
                        tr = (wre[k] * mr[g+p+h] - wim[k] * mi[g+p+h] + 16384) >>> 15;
                        ti = (wre[k] * mi[g+p+h] + wim[k] * mr[g+p+h] + 16384) >>> 15;
                    end
                    mr[g + p]     = sat((ar + tr) >>> 1);
                    mi[g + p]     = sat((ai + ti) >>> 1);
                    mr[g + p + h] = sat((ar - tr) >>> 1);
                    mi[g + p + h] = sat((ai - ti) >>> 1);
                end
            end
        end
        for (int k = 0; k < 8; k++) begin
            exp_re_q.push_back(int'(mr[k]));
            exp_im_q.push_back(int'(mi[k]));
        end
    endtask

    task automatic load();
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 3'(n);
            wr_re = 16'(xr[n]); wr_im = 16'(xi[n]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R3 timing on every run; disturb exercises R8.
    task automatic run(bit disturb);
        int cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R3 busy after start", int'(busy), 1);
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_re = 16'sd12345; wr_im = -16'sd777;
                start = 1'b1;
            end else begin
                wr_en = 1'b0; start = 1'b0;
            end
        end
        check(cyc == 12, disturb ? "R8 run length" : "R3 run length", cyc, 12);
        check(busy == 1'b0, "R3 busy low at done", int'(busy), 0);
    endtask

    task automatic monitor(string req);
        for (int k = 0; k < 8; k++) begin
            int er, ei;
            rd_addr = 3'(k);
            #1;
            er = exp_re_q.pop_front();
            ei = exp_im_q.pop_front();
            check(int'(rd_re) == er, req, int'(rd_re), er);
            check(int'(rd_im) == ei, req, int'(rd_im), ei);
        end
    endtask

    task automatic push_const(int re, int im);
        exp_re_q.push_back(re); exp_im_q.push_back(im);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        for (int k = 0; k < 8; k++) push_const(0, 0);
        monitor("R1 reset contents");

        // R4 / R2 impulse
        for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 8000;
        load(); run(1'b0);
        for (int k = 0; k < 8; k++) push_const(1000, 0);
        monitor("R4 impulse");

        // R5 constant
        for (int n = 0; n < 8; n++) begin xr[n] = 800; xi[n] = 0; end
        load(); run(1'b0);
        push_const(800, 0);
        for (int k = 1; k < 8; k++) push_const(0, 0);
        monitor("R5 constant");

        // R7 floor rounding
        for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 3; xi[0] = -3;
        load(); run(1'b0);
        for (int k = 0; k < 8; k++) push_const(0, -1);
        monitor("R7 floor");

        // R6 / R2 general patterns
        for (int n = 0; n < 8; n++) begin xr[n] = n * 1000 - 3500; xi[n] = 700 - n * 300; end
        load(); push_model(); run(1'b0);
        monitor("R6 ramp");
        for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[3] = 20000; xi[5] = -15000; xr[6] = -9001; xi[1] = 4321;
        load(); push_model(); run(1'b0);
        monitor("R6 sparse");

        // R7 saturation with near full-scale input
        for (int n = 0; n < 8; n++) begin
            xr[n] = (n % 2 == 0) ? -32768 : 32767;
            xi[n] = (n < 4) ? 32767 : -32768;
        end
        load(); push_model(); run(1'b0);
        monitor("R7 saturation");

        // R8 write and start during busy ignored
        for (int n = 0; n < 8; n++) begin xr[n] = 111 * n - 400; xi[n] = -57 * n + 90; end
        load(); push_model(); run(1'b1);
        monitor("R8 ignored during busy");

        // R9 done persists, results readable again, restart clears done
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R9 done held", int'(done), 1);
        push_model();
        monitor("R9 reread");
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9 done cleared by start", int'(done), 0);
        repeat (14) @(negedge clk);
        check(done == 1'b1, "R9 done after rerun", int'(done), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule